// File: doc/BRIEF.md
# USB DMA Channel Status Tracker

This block tracks the run state of six DMA channels that carry USB endpoint data into memory, and presents each channel's state as a read-only 32-bit status word at a fixed address. For each channel it follows an enable request and a start pulse, loads a byte count at start, and counts that count down on a per-byte strobe. It records three sticky events: a descriptor was fetched, the buffer count ran out, and a USB transfer closed the DMA transfer. Each event stays set until software reads that channel's word.

A channel closes either when its byte count reaches zero, or when a USB transfer completes while buffer-close is enabled. Closing clears both its enable bit and its active bit. A completed USB transfer always clears the active bit, whether or not it closes the channel. The status words sit at byte offsets starting at 0x31C, 0x10 apart. A read of any other offset returns zero.

Top module: `usb_dma_stat_tracker`

## Requirements
- R1: After reset every channel's status word reads 0x00000000.
- R2: A start pulse while the channel's enable request is 1 sets bit 0 (enabled) and bit 1 (active), and loads the supplied count into bits 31:16.
- R3: Each byte strobe while bit 0 is 1 lowers the count by one. A strobe while bit 0 is 0 leaves the count unchanged. A count of zero stays zero.
- R4: When a strobe brings the count from 1 to 0, bit 5 (end of buffer) sets and bits 0 and 1 clear.
- R5: A USB transfer-complete event clears bit 1. If buffer-close enable is 1 and the channel is enabled, it also sets bit 4 (end of transfer) and clears bit 0. If buffer-close enable is 0, bit 4 stays 0 and bit 0 keeps its value.
- R6: A descriptor-loaded event sets bit 6.
- R7: A read strobe at a channel's offset returns that channel's word and clears its bits 4, 5 and 6 on the following edge. Other channels are left unchanged.
- R8: If an event and a read of the same channel fall in the same cycle, the event's flag ends up set.
- R9: A read of an offset that maps to no channel returns zero and clears no flag.
- R10: Dropping a channel's enable request to 0 clears its bits 0 and 1.
- R11: Channel X (1 to 6) answers at byte offset 0x31C + (X-1)*0x10. Bits 3:2 and 15:7 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chEnReq | input | 6 | Per-channel enable request (level) |
| chStart | input | 6 | Per-channel start pulse |
| chLoadCnt | input | 96 | Per-channel start byte count; channel i uses bits 16*i+15:16*i |
| descLoaded | input | 6 | Per-channel descriptor-fetched event |
| usbXferDone | input | 6 | Per-channel USB transfer-complete event |
| bufCloseEn | input | 6 | Per-channel buffer-close enable |
| byteStrobe | input | 6 | Per-channel one-byte-moved strobe |
| regRead | input | 1 | Register read strobe |
| regAddr | input | 12 | Byte offset of the read |
| regData | output | 32 | Status word at regAddr, or zero when no channel answers there |

## Verification
The countdown is driven by bursts of strobes. Bursts that stop above zero and bursts that run through zero show whether the count moves one per strobe and whether reaching zero fires the buffer-end close. Strobes sent with the count already at zero, and strobes sent after the enable request is withdrawn, show the hold and ignore paths apart from ordinary counting. USB completion is applied with buffer-close set and with it clear, which separates the closing path from the path that only clears the active bit. Reads are aimed at the channel just touched, at a different channel, at an unmapped offset, and in the same cycle as an event. Together these show that a clear reaches only the addressed channel, and that a new event is not lost when a read lands in the same cycle.

// File: rtl/usb_dma_stat_pkg.sv
package usb_dma_stat_pkg;

  typedef struct packed {
    logic loadCnt;
    logic decCnt;
    logic setEn;
    logic clrEn;
    logic setAct;
    logic clrAct;
    logic setEot;
    logic setEob;
    logic setDesc;
    logic clrFlags;
  } ctlStrobes_t;

endpackage

// File: rtl/usb_dma_stat_ctl.sv
module usb_dma_stat_ctl
  import usb_dma_stat_pkg::*;
(
  input  logic        enReq,
  input  logic        start,
  input  logic        descLd,
  input  logic        usbDone,
  input  logic        closeEn,
  input  logic        byteStb,
  input  logic        readHit,
  input  logic        enBit,
  input  logic        cntIsZero,
  input  logic        cntIsOne,
  output ctlStrobes_t st
);

  logic doDec;
  logic bufEndEvt;
  logic xferEndEvt;

  always_comb begin
    doDec      = byteStb && enBit && !cntIsZero;
    bufEndEvt  = doDec && cntIsOne;
    xferEndEvt = usbDone && enBit && closeEn;

    st          = '0;
    st.loadCnt  = start && enReq;
    st.decCnt   = doDec;
    st.setEn    = start && enReq;
    st.clrEn    = !enReq || bufEndEvt || xferEndEvt;
    st.setAct   = start && enReq;
    st.clrAct   = !enReq || bufEndEvt || xferEndEvt || usbDone;
    st.setEot   = xferEndEvt;
    st.setEob   = bufEndEvt;
    st.setDesc  = descLd;
    st.clrFlags = readHit;
  end

endmodule

// File: rtl/usb_dma_stat_dp.sv
module usb_dma_stat_dp
  import usb_dma_stat_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      st,
  input  logic [CNT_W-1:0] loadVal,
  output logic             enBit,
  output logic             actBit,
  output logic             eotFlag,
  output logic             eobFlag,
  output logic             descFlag,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enBit    <= 1'b0;
      actBit   <= 1'b0;
      eotFlag  <= 1'b0;
      eobFlag  <= 1'b0;
      descFlag <= 1'b0;
      cnt      <= '0;
    end else begin
      if (st.setEn)       enBit <= 1'b1;
      else if (st.clrEn)  enBit <= 1'b0;

      if (st.setAct)      actBit <= 1'b1;
      else if (st.clrAct) actBit <= 1'b0;

      if (st.setEot)        eotFlag <= 1'b1;
      else if (st.clrFlags) eotFlag <= 1'b0;

      if (st.setEob)        eobFlag <= 1'b1;
      else if (st.clrFlags) eobFlag <= 1'b0;

      if (st.setDesc)       descFlag <= 1'b1;
      else if (st.clrFlags) descFlag <= 1'b0;

      if (st.loadCnt)     cnt <= loadVal;
      else if (st.decCnt) cnt <= cnt - 1'b1;
    end
  end

  // R3
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == '0 && !st.loadCnt) |=> (cnt == '0));

  // R4
  eob_close_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.decCnt && cnt == CNT_W'(1) && !st.setEn) |=> (eobFlag && !enBit && !actBit));

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.clrFlags && !st.setDesc) |=> !descFlag);

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.clrFlags && st.setDesc) |=> descFlag);

endmodule

// File: rtl/usb_dma_stat_tracker.sv
module usb_dma_stat_tracker
  import usb_dma_stat_pkg::*;
#(
  parameter int NUM_CH     = 6,
  parameter int CNT_W      = 16,
  parameter int ADDR_W     = 12,
  parameter int REG_BASE   = 'h31C,
  parameter int REG_STRIDE = 'h10
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_CH-1:0]       chEnReq,
  input  logic [NUM_CH-1:0]       chStart,
  input  logic [NUM_CH*CNT_W-1:0] chLoadCnt,
  input  logic [NUM_CH-1:0]       descLoaded,
  input  logic [NUM_CH-1:0]       usbXferDone,
  input  logic [NUM_CH-1:0]       bufCloseEn,
  input  logic [NUM_CH-1:0]       byteStrobe,
  input  logic                    regRead,
  input  logic [ADDR_W-1:0]       regAddr,
  output logic [CNT_W+15:0]       regData
);

  localparam int STAT_W = CNT_W + 16;

  logic [NUM_CH-1:0] addrHit;
  logic [STAT_W-1:0] chStat [NUM_CH];
  logic [NUM_CH-1:0] eotSeen;
  logic [NUM_CH-1:0] enSeen;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int CH_OFFS = REG_BASE + i * REG_STRIDE;

    ctlStrobes_t       st;
    logic              enBit, actBit, eotFlag, eobFlag, descFlag;
    logic [CNT_W-1:0]  cnt;

    assign addrHit[i] = (regAddr == ADDR_W'(CH_OFFS));

    usb_dma_stat_ctl u_ctl (
      .enReq     (chEnReq[i]),
      .start     (chStart[i]),
      .descLd    (descLoaded[i]),
      .usbDone   (usbXferDone[i]),
      .closeEn   (bufCloseEn[i]),
      .byteStb   (byteStrobe[i]),
      .readHit   (regRead && addrHit[i]),
      .enBit     (enBit),
      .cntIsZero (cnt == '0),
      .cntIsOne  (cnt == CNT_W'(1)),
      .st        (st)
    );

    usb_dma_stat_dp #(.CNT_W(CNT_W)) u_dp (
      .clk      (clk),
      .rstN     (rstN),
      .st       (st),
      .loadVal  (chLoadCnt[i*CNT_W +: CNT_W]),
      .enBit    (enBit),
      .actBit   (actBit),
      .eotFlag  (eotFlag),
      .eobFlag  (eobFlag),
      .descFlag (descFlag),
      .cnt      (cnt)
    );

    assign chStat[i] = {cnt, 9'b0, descFlag, eobFlag, eotFlag, 2'b0, actBit, enBit};
    assign eotSeen[i] = eotFlag;
    assign enSeen[i]  = enBit;

    // R5
    eot_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(eotSeen[i]) |-> $past(bufCloseEn[i]));

    // R10
    drop_en_chk: assert property (@(posedge clk) disable iff (!rstN)
      !chEnReq[i] |=> !enSeen[i]);
  end

  always_comb begin
    regData = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addrHit[i]) regData = chStat[i];
    end
  end

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addrHit == '0) |-> (regData == '0));

  // R11
  single_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(addrHit));

endmodule

// File: tb/usb_dma_stat_tracker_bench.sv
module usb_dma_stat_tracker_bench;

  localparam int NCH = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NCH-1:0]    chEnReq = '0, chStart = '0, descLoaded = '0;
  logic [NCH-1:0]    usbXferDone = '0, bufCloseEn = '0, byteStrobe = '0;
  logic [NCH*16-1:0] chLoadCnt = '0;
  logic              regRead = 1'b0;
  logic [11:0]       regAddr = '0;
  logic [31:0]       regData;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  usb_dma_stat_tracker u_usb_dma_stat_tracker (
    .clk(clk), .rstN(rstN), .chEnReq(chEnReq), .chStart(chStart),
    .chLoadCnt(chLoadCnt), .descLoaded(descLoaded), .usbXferDone(usbXferDone),
    .bufCloseEn(bufCloseEn), .byteStrobe(byteStrobe), .regRead(regRead),
    .regAddr(regAddr), .regData(regData)
  );

  function automatic logic [11:0] offs(int ch);
    return 12'(12'h31C + ch * 12'h10);
  endfunction

  task automatic checkEq(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, got, exp);
    end
  endtask

  // Read one offset with the read strobe; tasks start and end just after a negedge.
  task automatic readAt(logic [11:0] a, output logic [31:0] d);
    regAddr = a;
    regRead = 1'b1;
    #1 d = regData;
    @(negedge clk);
    regRead = 1'b0;
  endtask

  task automatic startCh(int ch, logic [15:0] n);
    chLoadCnt[ch*16 +: 16] = n;
    chEnReq[ch] = 1'b1;
    chStart[ch] = 1'b1;
    @(negedge clk);
    chStart[ch] = 1'b0;
  endtask

  task automatic strobes(int ch, int n);
    for (int k = 0; k < n; k++) begin
      byteStrobe[ch] = 1'b1;
      @(negedge clk);
    end
    byteStrobe[ch] = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int c = 0; c < NCH; c++) begin
      readAt(offs(c), d);
      checkEq("R1 reset word", d, 32'h0);
    end
  endtask

  task automatic t_countdown();
    logic [31:0] d;
    startCh(0, 16'd5);
    readAt(offs(0), d);
    checkEq("R2 start loads count and sets en/act (R11 ch1 offset)", d, 32'h0005_0003);
    strobes(0, 3);
    readAt(offs(0), d);
    checkEq("R3 three strobes", d, 32'h0002_0003);
    strobes(0, 2);
    readAt(offs(0), d);
    checkEq("R4 count hits zero closes channel", d, 32'h0000_0020);
    readAt(offs(0), d);
    checkEq("R7 flag cleared by read", d, 32'h0);
    startCh(0, 16'd0);
    strobes(0, 3);
    readAt(offs(0), d);
    checkEq("R3 zero count holds, no wrap", d, 32'h0000_0003);
    chEnReq[0] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    startCh(1, 16'd4);
    chEnReq[1] = 1'b0;
    @(negedge clk);
    readAt(offs(1), d);
    checkEq("R10 dropping enable request", d, 32'h0004_0000);
    strobes(1, 2);
    readAt(offs(1), d);
    checkEq("R3 strobes ignored while disabled", d, 32'h0004_0000);
  endtask

  task automatic t_usbDone();
    logic [31:0] d;
    startCh(2, 16'd10);
    bufCloseEn[2] = 1'b0;
    usbXferDone[2] = 1'b1;
    @(negedge clk);
    usbXferDone[2] = 1'b0;
    readAt(offs(2), d);
    checkEq("R5 usb done without buffer close", d, 32'h000A_0001);
    startCh(3, 16'd10);
    bufCloseEn[3] = 1'b1;
    usbXferDone[3] = 1'b1;
    @(negedge clk);
    usbXferDone[3] = 1'b0;
    readAt(offs(3), d);
    checkEq("R5 usb done with buffer close", d, 32'h000A_0010);
    readAt(offs(3), d);
    checkEq("R7 end-of-transfer cleared by read", d, 32'h000A_0000);
    chEnReq[2] = 1'b0;
    chEnReq[3] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_desc();
    logic [31:0] d;
    descLoaded[4] = 1'b1;
    @(negedge clk);
    descLoaded[4] = 1'b0;
    readAt(offs(5), d);
    checkEq("R7 read of other channel", d, 32'h0);
    readAt(offs(4), d);
    checkEq("R6 descriptor flag set, untouched by other read", d, 32'h0000_0040);
    readAt(offs(4), d);
    checkEq("R7 descriptor flag cleared", d, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    descLoaded[5] = 1'b1;
    readAt(offs(5), d);
    descLoaded[5] = 1'b0;
    checkEq("R8 read in event cycle sees old word", d, 32'h0);
    readAt(offs(5), d);
    checkEq("R8 event wins over same-cycle read", d, 32'h0000_0040);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    descLoaded[0] = 1'b1;
    @(negedge clk);
    descLoaded[0] = 1'b0;
    readAt(12'h320, d);
    checkEq("R9 unmapped offset reads zero", d, 32'h0);
    readAt(12'h000, d);
    checkEq("R9 offset zero reads zero", d, 32'h0);
    readAt(12'h37C, d);
    checkEq("R11 offset past channel 6 reads zero", d, 32'h0);
    readAt(12'h31C, d);
    checkEq("R9 no flag cleared by unmapped read", d, 32'h0000_0040);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_countdown();
    t_disable();
    t_usbDone();
    t_desc();
    t_collide();
    t_unmapped();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule